// File: doc/BRIEF.md
# Software-Pipelined Loop Stage Sequencer

This block drives a modulo-scheduled inner loop when only the steady-state body (the kernel) is held in instruction memory. The body is cut into S stages. Each kernel operation carries the number of the stage it belongs to, and the issue logic lets it through only when that stage's enable bit is high. The sequencer walks a kernel instruction index over the kernel, one instruction per cycle. On every wrap of that index it updates a stage-enable mask. The mask first fills from the earliest stage upward, then stays full, then empties from the earliest stage. In this way the ramp-in and ramp-out passes are taken from the kernel itself, and no separate code is needed for them.

A one-cycle start pulse loads the stage count, the kernel length and the iteration count. The block then shows the current kernel index and mask, flags the first instruction of each pass in which a new iteration enters, and pulses a done flag for one cycle when the loop has drained. For N iterations the loop takes N + S − 1 kernel passes.

Top module: `loop_stage_seq`

## Requirements
- R1: After synchronous reset the sequencer is idle: `busy_o`, `done_o` and `iter_start_o` are 0, `stage_en_o` is all zeros and `kidx_o` is 0.
- R2: A start while idle with a non-zero iteration count makes `busy_o` high from the next cycle. In that first cycle `kidx_o` is 0 and `stage_en_o` has only bit 0 set. Bit k−1 of `stage_en_o` is the enable for stage k, so stage 1 is bit 0.
- R3: While busy, `kidx_o` steps by one each cycle from 0 to kernel length − 1 and then wraps to 0. `stage_en_o` changes only on that wrap.
- R4: In the ramp-in passes the mask gains one bit per pass, from bit 0 upward.
- R5: Once ramp-in is over, bits 0 to S−1 are all set. Bits at S and above are never set.
- R6: In the ramp-out passes bit 0 clears first, and the mask shrinks by one low bit per pass until only bit S−1 remains.
- R7: For any N ≥ 1, including N < S, bit k−1 is set during pass p (counted from 0) exactly when 0 ≤ p − (k−1) < N.
- R8: `busy_o` stays high for exactly (N + S − 1) × kernel length cycles. In the next cycle `done_o` is high for one cycle with `busy_o` low and the mask clear.
- R9: `iter_start_o` is high in a cycle exactly when `kidx_o` is 0 and bit 0 of the mask is set, so it pulses N times per loop, the first time in the first busy cycle.
- R10: A start with an iteration count of 0 gives a `done_o` pulse in the next cycle. `busy_o` stays low and no stage bit is ever set.
- R11: A start while busy is ignored. The loop in progress keeps the configuration it latched at its own start.
- R12: Reset asserted during a loop returns the sequencer to the idle state of R1, and a later start runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, taken only while idle |
| stages_i | input | $clog2(MAX_STAGES+1) | Stage count S, 1 to MAX_STAGES |
| klen_i | input | KIDX_W | Kernel length in instructions, at least 1 |
| iters_i | input | ITER_W | Iteration count N |
| busy_o | output | 1 | Loop in progress |
| kidx_o | output | KIDX_W | Kernel instruction index |
| stage_en_o | output | MAX_STAGES | Stage enable mask, bit k−1 for stage k |
| iter_start_o | output | 1 | A new iteration enters on this instruction |
| done_o | output | 1 | One-cycle pulse after the last pass |

## Verification
The bench aims at fewer iterations than stages. A mask that has to fill completely before it can drain would show stage bits that no iteration uses. Single-stage and single-instruction kernels test the wrap and the stage limit: a faulty limit lets bits above S leak out, and a faulty wrap compare runs one pass too many or too few. A zero iteration count must give done without any stage bit set, and a start that arrives in mid-loop must not reload the kernel length or restart the count, which would show up as a wrong index sequence or an early done.

// File: rtl/loop_stage_seq.sv
module loop_stage_seq #(
  parameter int MAX_STAGES = 4,
  parameter int KIDX_W     = 6,
  parameter int ITER_W     = 8,
  localparam int SW        = $clog2(MAX_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [SW-1:0]         stages_i,
  input  logic [KIDX_W-1:0]     klen_i,
  input  logic [ITER_W-1:0]     iters_i,
  output logic                  busy_o,
  output logic [KIDX_W-1:0]     kidx_o,
  output logic [MAX_STAGES-1:0] stage_en_o,
  output logic                  iter_start_o,
  output logic                  done_o
);

  logic                  busy_q, done_q;
  logic [KIDX_W-1:0]     kidx_q, klen_q;
  logic [SW-1:0]         stages_q;
  logic [ITER_W-1:0]     iters_q, entered_q;
  logic [MAX_STAGES-1:0] mask_q;

  wire                  pass_end   = kidx_q == klen_q - 1'b1;
  wire                  more_iters = entered_q < iters_q;
  wire [MAX_STAGES-1:0] stage_lim  = ~({MAX_STAGES{1'b1}} << stages_q);
  wire [MAX_STAGES-1:0] mask_nxt   = {mask_q[MAX_STAGES-2:0], more_iters} & stage_lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      kidx_q    <= '0;
      klen_q    <= '0;
      stages_q  <= '0;
      iters_q   <= '0;
      entered_q <= '0;
      mask_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          if (iters_i == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q    <= 1'b1;
            kidx_q    <= '0;
            klen_q    <= klen_i;
            stages_q  <= stages_i;
            iters_q   <= iters_i;
            entered_q <= ITER_W'(1);
            mask_q    <= MAX_STAGES'(1);
          end
        end
      end else if (pass_end) begin
        kidx_q <= '0;
        mask_q <= mask_nxt;
        if (more_iters) entered_q <= entered_q + 1'b1;
        if (mask_nxt == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        kidx_q <= kidx_q + 1'b1;
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign kidx_o       = kidx_q;
  assign stage_en_o   = mask_q;
  assign iter_start_o = busy_q && (kidx_q == '0) && mask_q[0];

endmodule

// File: rtl/loop_stage_seq_chk.sv
module loop_stage_seq_chk #(
  parameter int MAX_STAGES = 4,
  parameter int KIDX_W     = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy_o,
  input logic [KIDX_W-1:0]     kidx_o,
  input logic [MAX_STAGES-1:0] stage_en_o,
  input logic                  iter_start_o,
  input logic                  done_o
);

  wire [MAX_STAGES-1:0] low_bit = stage_en_o & (~stage_en_o + 1'b1);
  wire [MAX_STAGES-1:0] run_sum = stage_en_o + low_bit;

  AST_IDLE_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> stage_en_o == '0);  // R1
  AST_FIRST_PASS_STAGE1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> stage_en_o == MAX_STAGES'(1));  // R2
  AST_MASK_HOLD_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    (busy_o && kidx_o != '0) |-> $stable(stage_en_o));  // R3
  AST_MASK_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    (run_sum & stage_en_o) == '0);  // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);  // R8
  AST_DONE_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);  // R8
  AST_FIRST_ITER_ENTERS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> iter_start_o);  // R9

endmodule

bind loop_stage_seq loop_stage_seq_chk #(
  .MAX_STAGES(MAX_STAGES),
  .KIDX_W(KIDX_W)
) chk_i (
  .clk(clk),
  .rst(rst),
  .busy_o(busy_o),
  .kidx_o(kidx_o),
  .stage_en_o(stage_en_o),
  .iter_start_o(iter_start_o),
  .done_o(done_o)
);

// File: tb/loop_stage_seq_tb_top.sv
`timescale 1ns/1ps
module loop_stage_seq_tb_top;
  localparam int MS = 4;
  localparam int KW = 6;
  localparam int IW = 8;
  localparam int SW = $clog2(MS + 1);

  // stage count, kernel length, iterations, expected passes
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{4, 3, 6, 9}, '{4, 2, 2, 5}, '{3, 1, 5, 7}, '{1, 4, 3, 3},
    '{2, 5, 1, 2}, '{4, 1, 4, 7}, '{3, 2, 3, 5}, '{4, 2, 9, 12}
  };

  logic clk = 0, rst = 1, start_i = 0;
  logic [SW-1:0] stages_i = '0;
  logic [KW-1:0] klen_i = '0;
  logic [IW-1:0] iters_i = '0;
  logic busy_o, iter_start_o, done_o;
  logic [KW-1:0] kidx_o;
  logic [MS-1:0] stage_en_o;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  loop_stage_seq #(.MAX_STAGES(MS), .KIDX_W(KW), .ITER_W(IW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .stages_i(stages_i),
    .klen_i(klen_i), .iters_i(iters_i), .busy_o(busy_o), .kidx_o(kidx_o),
    .stage_en_o(stage_en_o), .iter_start_o(iter_start_o), .done_o(done_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_mask(input int s, input int n, input int p);
    int m = 0;
    for (int k = 1; k <= s; k++)
      if (p - (k - 1) >= 0 && p - (k - 1) < n) m |= 1 << (k - 1);
    return m;
  endfunction

  task automatic check_idle(input string tag);
    chk(busy_o == 0 && done_o == 0 && iter_start_o == 0, {tag, " flags"},
        {busy_o, done_o, iter_start_o}, 0);
    chk(stage_en_o == 0 && kidx_o == 0, {tag, " mask/index"}, int'(stage_en_o), 0);
  endtask

  task automatic run_cfg(input int s, input int k, input int n, input int passes, input bit poke);
    int total = passes * k;
    int starts = 0;
    @(negedge clk);
    stages_i = SW'(s); klen_i = KW'(k); iters_i = IW'(n); start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o && kidx_o == 0 && stage_en_o == 1, "R2 first busy cycle", int'(stage_en_o), 1);
    chk(passes == n + s - 1, "R8 pass count", passes, n + s - 1);
    for (int c = 0; c < total; c++) begin
      int p = c / k;
      int em = exp_mask(s, n, p);
      string tg = (n < s) ? "R7 short loop mask" : (p < s - 1) ? "R4 ramp-in mask" :
                  (p < n) ? "R5 full mask" : "R6 ramp-out mask";
      chk(busy_o == 1 && done_o == 0, "R8 busy window", busy_o, 1);
      chk(int'(kidx_o) == c % k, "R3 kernel index", int'(kidx_o), c % k);
      chk(int'(stage_en_o) == em, tg, int'(stage_en_o), em);
      chk(iter_start_o == (c % k == 0 && p < n), "R9 iteration start", iter_start_o,
          int'(c % k == 0 && p < n));
      if (iter_start_o) starts++;
      if (poke && c == 1) begin
        start_i = 1; stages_i = 1; klen_i = 7; iters_i = 0;
      end
      if (poke && c == 2) start_i = 0;
      @(negedge clk);
    end
    chk(done_o == 1 && busy_o == 0 && stage_en_o == 0, poke ? "R11 done after ignored start" : "R8 done pulse",
        done_o, 1);
    chk(starts == n, "R9 iteration start count", starts, n);
    @(negedge clk);
    chk(done_o == 0, "R8 done single cycle", done_o, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst = 0;
    for (int v = 0; v < NV; v++) run_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 0);

    // R10: zero iterations
    @(negedge clk);
    stages_i = 3; klen_i = 2; iters_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(done_o == 1 && busy_o == 0 && stage_en_o == 0, "R10 zero-iteration done", done_o, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(done_o == 0 && busy_o == 0 && stage_en_o == 0, "R10 stays idle", int'(stage_en_o), 0);
    end

    // R11: start during a loop is ignored
    run_cfg(3, 3, 4, 6, 1);

    // R12: reset mid-loop
    @(negedge clk);
    stages_i = 3; klen_i = 2; iters_i = 4; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check_idle("R12 mid-loop reset");
    run_cfg(2, 2, 3, 4, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule